// File: doc/BRIEF.md
# Streaming GF(2) Encryption Datapath

This block turns a binary message into a ciphertext word. The message is a row vector of `K` bits. A fixed binary generating matrix with `K` rows and `N` columns is built into the block at elaboration. One column of that matrix is read on each clock cycle. For each column, every message bit is ANDed with the matching column bit and the products are folded together with XOR, which gives one codeword bit. After all `N` columns have been visited, a caller-supplied random error vector is XORed onto the whole codeword. The result is presented as the ciphertext.

A caller drives the message and the error vector, then pulses `start`. Both operands are captured on that edge. The caller may change its inputs straight away, because the block works only from its captured copies. Exactly `N` cycles later a one-cycle `done` pulse marks a fresh `ciphertext`, and that value stays put until the next job finishes.

The matrix is normally systematic: identity columns come first, followed by the parity columns. The block does not depend on that layout, and any column order works. The block has no multipliers and no adders.

Top module: `gf2_stream_encryptor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `done` is 0 and `ciphertext` is all zeros.
- R2: Column `j` of the matrix occupies bits `[j*K +: K]` of parameter `GEN_MATRIX`, and bit `i` of that column pairs with `message[i]`. Ciphertext bit `j` equals the XOR over all `i` of (`message[i]` AND column bit `i`), XORed with `error_vec[j]`.
- R3: For a matrix whose first `K` columns are the identity, with a zero error vector, `ciphertext[K-1:0]` equals the message.
- R4: The error vector is applied bitwise: setting only `error_vec[j]` flips only `ciphertext[j]` relative to the zero-error result.
- R5: If `start` is sampled high on edge E while the block is idle, `done` is high for exactly the one cycle following edge E+N.
- R6: A `start` pulse that arrives while a job is running is ignored. The job completes with the first operands, and no extra `done` follows.
- R7: Message and error vector are captured on the accepted `start` edge. Changes to those inputs during the job do not alter its result.
- R8: `ciphertext` changes only on the cycle in which `done` is high, and holds its value between jobs.
- R9: The datapath is correct for any column order. Reversing the matrix columns reverses the zero-error ciphertext bit order.
- R10: An all-zero message yields a ciphertext equal to the error vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request; accepted only while idle |
| message | input | K | Plaintext row vector, captured at an accepted start |
| error_vec | input | N | Random error pattern, captured at an accepted start |
| ciphertext | output | N | Encoded word with errors added; updated when done pulses |
| done | output | 1 | One-cycle pulse marking a new ciphertext |

## Verification
The bench builds the block twice, both with `K`=4 and `N`=8. The first copy holds a systematic matrix, with four identity columns followed by four weight-three parity columns. The second copy holds the same columns in reverse order. The identity columns expose the message directly, which makes the systematic pass-through and single-bit error flips visible. Comparing the two copies on the same inputs shows that the datapath does not depend on column order. With eight columns, the exact latency is checked, and a second start can be placed in the middle of a job.

// File: rtl/gf2enc_pkg.sv
package gf2enc_pkg;

    typedef enum logic {
        ENC_IDLE = 1'b0,
        ENC_RUN  = 1'b1
    } enc_state_e;

    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/gf2_col_rom.sv
module gf2_col_rom #(
    parameter int K = 4,
    parameter int N = 8,
    parameter logic [K*N-1:0] MAT = '0,
    localparam int IW = gf2enc_pkg::idx_width(N)
) (
    input  logic [IW-1:0] col_idx,
    output logic [K-1:0]  col_bits
);

    logic [K-1:0] columns [N];

    for (genvar j = 0; j < N; j++) begin : g_col
        assign columns[j] = MAT[j*K +: K];
    end

    always_comb begin
        col_bits = '0;
        for (int j = 0; j < N; j++) begin
            if (col_idx == IW'(j)) col_bits = columns[j];
        end
    end

    always_comb begin
        if (!$isunknown(col_idx)) begin
            assert_col_in_range_R2: assert (int'(col_idx) < N)
                else $error("column index beyond matrix width");
        end
    end

endmodule

// File: rtl/gf2_col_dot.sv
module gf2_col_dot #(
    parameter int K = 4
) (
    input  logic [K-1:0] row_vec,
    input  logic [K-1:0] col_vec,
    output logic         bit_o
);

    logic [K-1:0] prod;

    for (genvar i = 0; i < K; i++) begin : g_and
        assign prod[i] = row_vec[i] & col_vec[i];
    end

    assign bit_o = ^prod;

endmodule

// File: rtl/gf2_enc_seq.sv
module gf2_enc_seq #(
    parameter int N = 8,
    localparam int IW = gf2enc_pkg::idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          launch,
    output logic          last,
    output logic [IW-1:0] col_idx
);
    import gf2enc_pkg::*;

    localparam logic [IW-1:0] LAST_COL = IW'(N - 1);

    enc_state_e    state_q;
    logic [IW-1:0] col_q;

    assign busy    = (state_q == ENC_RUN);
    assign launch  = start && !busy;
    assign last    = busy && (col_q == LAST_COL);
    assign col_idx = col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENC_IDLE;
            col_q   <= '0;
        end else begin
            unique case (state_q)
                ENC_IDLE: begin
                    col_q <= '0;
                    if (start) state_q <= ENC_RUN;
                end
                ENC_RUN: begin
                    if (col_q == LAST_COL) begin
                        state_q <= ENC_IDLE;
                        col_q   <= '0;
                    end else begin
                        col_q <= col_q + IW'(1);
                    end
                end
                default: state_q <= ENC_IDLE;
            endcase
        end
    end

    assert_col_advances_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && col_q == $past(col_q) + IW'(1)));

    assert_run_ends_R5: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !last && start) |=> (busy && col_q != '0));

endmodule

// File: rtl/gf2_stream_encryptor.sv
module gf2_stream_encryptor #(
    parameter int K = 4,
    parameter int N = 8,
    parameter logic [K*N-1:0] GEN_MATRIX = 32'hEDB7_8421
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [K-1:0] message,
    input  logic [N-1:0] error_vec,
    output logic [N-1:0] ciphertext,
    output logic         done
);
    localparam int IW = gf2enc_pkg::idx_width(N);

    typedef struct packed {
        logic [K-1:0] msg;
        logic [N-1:0] err;
    } operand_t;

    operand_t      opnd_q;
    logic          busy, launch, last;
    logic [IW-1:0] col_idx;
    logic [K-1:0]  col_bits;
    logic          code_bit;
    logic [N-1:0]  cw_q, cw_fill;
    logic [N-1:0]  ct_q;
    logic          done_q;

    gf2_enc_seq #(.N(N)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .busy    (busy),
        .launch  (launch),
        .last    (last),
        .col_idx (col_idx)
    );

    gf2_col_rom #(.K(K), .N(N), .MAT(GEN_MATRIX)) u_rom (
        .col_idx  (col_idx),
        .col_bits (col_bits)
    );

    gf2_col_dot #(.K(K)) u_dot (
        .row_vec (opnd_q.msg),
        .col_vec (col_bits),
        .bit_o   (code_bit)
    );

    always_comb begin
        cw_fill = cw_q;
        for (int j = 0; j < N; j++) begin
            if (col_idx == IW'(j)) cw_fill[j] = code_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
            cw_q   <= '0;
            ct_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                opnd_q.msg <= message;
                opnd_q.err <= error_vec;
                cw_q       <= '0;
            end else if (busy) begin
                cw_q <= cw_fill;
                if (last) begin
                    ct_q   <= cw_fill ^ opnd_q.err;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign ciphertext = ct_q;
    assign done       = done_q;

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_run_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    assert_ct_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ciphertext));

    assert_operands_held_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(opnd_q));

endmodule

// File: tb/sim_gf2_stream_encryptor.sv
module sim_gf2_stream_encryptor;

    localparam int K = 4;
    localparam int N = 8;
    localparam logic [K*N-1:0] MAT_A = 32'hEDB7_8421;
    localparam logic [K*N-1:0] MAT_B = 32'h1248_7BDE;

    localparam int NV = 6;
    localparam logic [K+N-1:0] VEC [NV] = '{
        {4'h1, 8'h00}, {4'h2, 8'h00}, {4'h7, 8'h10},
        {4'h9, 8'hC3}, {4'hE, 8'h01}, {4'h5, 8'hFF}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [K-1:0] msg = '0;
    logic [N-1:0] err = '0;
    logic [N-1:0] ct_a, ct_b;
    logic         done_a, done_b;
    int           checks = 0;
    int           errors = 0;

    always #5 clk = ~clk;

    gf2_stream_encryptor #(.K(K), .N(N), .GEN_MATRIX(MAT_A)) u0 (
        .clk(clk), .rst(rst), .start(start), .message(msg),
        .error_vec(err), .ciphertext(ct_a), .done(done_a)
    );

    gf2_stream_encryptor #(.K(K), .N(N), .GEN_MATRIX(MAT_B)) u1 (
        .clk(clk), .rst(rst), .start(start), .message(msg),
        .error_vec(err), .ciphertext(ct_b), .done(done_b)
    );

    function automatic logic [N-1:0] ref_enc(input logic [K*N-1:0] mat,
                                             input logic [K-1:0] m,
                                             input logic [N-1:0] e);
        logic [N-1:0] r;
        for (int j = 0; j < N; j++) begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i < K; i++) acc = acc ^ (m[i] & mat[j*K + i]);
            r[j] = acc ^ e[j];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] reverse(input logic [N-1:0] v);
        logic [N-1:0] r;
        for (int j = 0; j < N; j++) r[j] = v[N-1-j];
        return r;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic kick(input logic [K-1:0] m, input logic [N-1:0] e);
        @(negedge clk);
        start = 1'b1;
        msg   = m;
        err   = e;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Timing per R5: done must be low at the N-th negedge and high at the next.
    task automatic run_check(input logic [K-1:0] m, input logic [N-1:0] e,
                             input string req);
        kick(m, e);
        repeat (N - 1) @(negedge clk);
        check("R5 early", N'(done_a), N'(1'b0));
        @(negedge clk);
        check("R5 done", N'(done_a), N'(1'b1));
        check(req, ct_a, ref_enc(MAT_A, m, e));
        check("R9 permuted", ct_b, ref_enc(MAT_B, m, e));
        @(negedge clk);
        check("R5 pulse", N'(done_a), N'(1'b0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] base, held;
        int extra_done;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 ct in reset", ct_a, '0);
        check("R1 done in reset", N'(done_a), '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ct after reset", ct_a, '0);
        check("R1 done after reset", N'(done_a), '0);

        // R2: vector table
        for (int v = 0; v < NV; v++) begin
            run_check(VEC[v][K+N-1:N], VEC[v][N-1:0], "R2 table");
        end

        // R3: systematic pass-through
        run_check(4'hA, 8'h00, "R3 run");
        check("R3 systematic", N'(ct_a[K-1:0]), N'(4'hA));

        // R4: single error bit flips one ciphertext bit
        run_check(4'h5, 8'h00, "R4 base");
        base = ct_a;
        run_check(4'h5, 8'h40, "R4 flip");
        check("R4 single flip", ct_a, base ^ 8'h40);

        // R10: zero message and all-ones message
        run_check(4'h0, 8'h5A, "R10 zero msg");
        check("R10 equals error", ct_a, 8'h5A);
        run_check(4'hF, 8'h00, "R10 ones");

        // R6: second start mid-job is ignored
        kick(4'h3, 8'h00);
        repeat (2) @(negedge clk);
        start = 1'b1;
        msg   = 4'hC;
        err   = 8'hFF;
        @(negedge clk);
        start = 1'b0;
        repeat (N - 4) @(negedge clk);
        check("R6 no early done", N'(done_a), '0);
        @(negedge clk);
        check("R6 done once", N'(done_a), N'(1'b1));
        check("R6 first operands", ct_a, ref_enc(MAT_A, 4'h3, 8'h00));
        extra_done = 0;
        for (int c = 0; c < N + 3; c++) begin
            @(negedge clk);
            if (done_a) extra_done++;
        end
        check("R6 no extra done", N'(extra_done), '0);

        // R7: inputs change during the job
        kick(4'h6, 8'h81);
        msg = 4'h9;
        err = 8'hFF;
        repeat (N) @(negedge clk);
        check("R7 latched done", N'(done_a), N'(1'b1));
        check("R7 latched operands", ct_a, ref_enc(MAT_A, 4'h6, 8'h81));

        // R8: ciphertext holds between jobs
        held = ct_a;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            msg = 4'(c);
            err = 8'(c * 37);
        end
        check("R8 hold", ct_a, held);

        // R9: reversed columns reverse the codeword
        run_check(4'hB, 8'h00, "R9 run");
        check("R9 reversed", ct_b, reverse(ct_a));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule